// File: doc/BRIEF.md
# Bit-Serial SIMD Column Processing Array

This block is a row of identical column processing elements that all obey one shared sequencer. Each element owns one image column. Each one sees five vertically stacked 4-bit pixels of that column, a 32-bit work store, a carry flag and an 8-bit result register. Every cycle the sequencer issues one microinstruction to all elements at once. Each element then computes one bit of a result. Multi-bit arithmetic is therefore spelled out in the program, one bit per word, least significant bit first. The carry flag links successive words. An N-bit add with its carry-out takes N+1 words.

Operands come from a pixel bit of any of the five rows, from a bit of the left or right neighbour's work store, or from the element's own work store. A line-start pulse restarts the sequencer at the first word of one of four equal program slots, chosen by a select input at that moment. A jump word redirects fetch. A simple write port fills the instruction memory. A typical use loads a 4-neighbour sum or a filter kernel into one slot and fires the line-start pulse once per row.

Top module: `pe_array`

## Requirements
- R1: After reset, every result register and every work bit is 0. The sequencer issues only no-ops until the first line-start pulse.
- R2: A line-start pulse on `hsync` restarts fetch at address `prog_sel`×(DEPTH/4) and flushes the issue stage. The first word of the slot executes at the second rising edge after the one that samples the pulse. A pulse in the middle of a program abandons that program.
- R3: Without a pulse or a jump, the fetch address advances by one each cycle, so one word issues per cycle.
- R4: Op code 8 is a jump to the target field. The word that follows the jump in memory never executes, and the target word issues after exactly one bubble. A jump to its own address holds the array idle.
- R5: Op 1 (add) computes a+b+c, and op 2 (subtract) computes a+~b+c. Here c is the `cin_val` field when `cin_ld` is set, and the carry flag otherwise. The carry-out is stored in the flag.
- R6: Op 3 is AND, op 4 is OR, op 5 is XOR, and op 6 copies operand a.
- R7: Op 7 writes the effective carry c as its result bit, which stores the borrow/carry-out of a finished operation.
- R8: Source select codes 0 to 4 read a pixel row. For these the low 3 bits of the address field give the bit index, and an index of 4 or more reads 0. Code 5 reads the left neighbour's work bit at the address field, code 6 reads the right neighbour's, and code 7 reads the element's own work bit.
- R9: The leftmost element reads 0 from its missing left neighbour, and the rightmost reads 0 from its missing right neighbour.
- R10: A result bit is written to the result register bit `out_bit` only when `out_we` is set on an executing word. The result register holds otherwise, even when the pixel inputs change.
- R11: A write on the instruction-memory port replaces that word, and the new word governs every later run of its slot.
- R12: The word layout, from bit 0 upward, is: op[3:0], a_sel[6:4], a_addr[11:7], b_sel[14:12], b_addr[19:15], dst[24:20], dst_we[25], out_we[26], out_bit[29:27], cin_ld[30], cin_val[31], jump target[31+AW:32]. Op 0 is a no-op, which changes no state whatever its other fields hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hsync | input | 1 | Line-start pulse that restarts the sequencer |
| prog_sel | input | 2 | Program slot taken at the line-start pulse |
| im_we | input | 1 | Instruction memory write enable |
| im_addr | input | AW (7) | Instruction memory write address |
| im_wdata | input | 32+AW (39) | Instruction word to write |
| taps | input | NPE*5*PIX_W (160) | Pixel rows; element p, row r sits at bit ((p*5)+r)*PIX_W |
| pe_out | output | NPE*8 (64) | Result registers; element p in bits 8p+7..8p |

## Verification
A line-start pulse sampled at edge E moves the sequencer to the slot base at E. The first slot word is latched at E+1, and its result bit shows at E+2. Each later word adds one edge, and each jump adds one bubble edge. Every program in the bench ends in a self-jump, so after a fixed 40-cycle wait the result registers are settled. The bench samples them on the falling edge. The hold check changes the pixels after a program has ended and samples again 20 cycles later. The mid-program restart check fires the second pulse three cycles into a run, before any result bit of the abandoned program is written.

// File: rtl/pe_pkg.sv
package pe_pkg;
  localparam int NTAP   = 5;   // pixel rows per column (select codes 0..4)
  localparam int WORK_W = 32;  // work store bits per element
  localparam int OUT_W  = 8;   // result register bits per element
  localparam int SEL_W  = 3;
  localparam int ADR_W  = $clog2(WORK_W);
  localparam int OBIT_W = $clog2(OUT_W);

  localparam logic [SEL_W-1:0] SRC_LEFT  = 3'd5;
  localparam logic [SEL_W-1:0] SRC_RIGHT = 3'd6;
  localparam logic [SEL_W-1:0] SRC_OWN   = 3'd7;

  typedef enum logic [3:0] {
    OP_NOP = 4'd0, OP_ADD = 4'd1, OP_SUB = 4'd2, OP_AND = 4'd3,
    OP_OR  = 4'd4, OP_XOR = 4'd5, OP_MOV = 4'd6, OP_CRY = 4'd7,
    OP_JMP = 4'd8
  } op_e;

  typedef struct packed {
    logic              cin_val;
    logic              cin_ld;
    logic [OBIT_W-1:0] out_bit;
    logic              out_we;
    logic              dst_we;
    logic [ADR_W-1:0]  dst;
    logic [ADR_W-1:0]  b_addr;
    logic [SEL_W-1:0]  b_sel;
    logic [ADR_W-1:0]  a_addr;
    logic [SEL_W-1:0]  a_sel;
    op_e               op;
  } pe_ctrl_t;

  localparam int CTRL_W = $bits(pe_ctrl_t);

  // one bit-serial step: returns {carry_out, result}
  function automatic logic [1:0] alu_step(op_e op, logic a, logic b, logic c);
    logic bb;
    bb = (op == OP_SUB) ? ~b : b;
    case (op)
      OP_ADD, OP_SUB: return {(a & bb) | (a & c) | (bb & c), a ^ bb ^ c};
      OP_AND:         return {c, a & b};
      OP_OR:          return {c, a | b};
      OP_XOR:         return {c, a ^ b};
      OP_MOV:         return {c, a};
      OP_CRY:         return {c, c};
      default:        return {c, 1'b0};
    endcase
  endfunction

  function automatic logic executes(op_e op);
    return (op != OP_NOP) && (op != OP_JMP);
  endfunction
endpackage

// File: rtl/pe_seq.sv
module pe_seq
  import pe_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int SLOTS = 4,
  localparam int AW = $clog2(DEPTH),
  localparam int SW = $clog2(SLOTS),
  localparam int IW = CTRL_W + AW,
  localparam int SLOT_SZ = DEPTH / SLOTS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hsync,
  input  logic [SW-1:0] prog_sel,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [IW-1:0] wdata,
  output pe_ctrl_t      issue,
  output logic [AW-1:0] pc_o,
  output logic [AW-1:0] tgt_o,
  output logic          jump_o,
  output logic          run_o
);
  logic [IW-1:0] mem [DEPTH];
  logic [IW-1:0] ir_q;
  logic [AW-1:0] pc_q;
  logic          run_q;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign issue  = pe_ctrl_t'(ir_q[CTRL_W-1:0]);
  assign tgt_o  = ir_q[IW-1:CTRL_W];
  assign jump_o = run_q && (issue.op == OP_JMP);
  assign pc_o   = pc_q;
  assign run_o  = run_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q  <= '0;
      ir_q  <= '0;
      run_q <= 1'b0;
    end else if (hsync) begin
      pc_q  <= AW'(int'(prog_sel) * SLOT_SZ);
      ir_q  <= '0;
      run_q <= 1'b1;
    end else if (run_q) begin
      if (jump_o) begin
        pc_q <= tgt_o;
        ir_q <= '0;
      end else begin
        ir_q <= mem[pc_q];
        pc_q <= pc_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pe_cell.sv
module pe_cell
  import pe_pkg::*;
#(
  parameter int PIX_W = 4,
  localparam int TAP_W = NTAP * PIX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  pe_ctrl_t          ctrl,
  input  logic [TAP_W-1:0]  taps,
  input  logic [WORK_W-1:0] left_work,
  input  logic [WORK_W-1:0] right_work,
  output logic [WORK_W-1:0] work_o,
  output logic [OUT_W-1:0]  out_o
);
  logic [WORK_W-1:0] work_q;
  logic [OUT_W-1:0]  out_q;
  logic              carry_q;
  logic              opa, opb, c_eff, res, cout;

  function automatic logic pick(logic [SEL_W-1:0] sel, logic [ADR_W-1:0] addr,
                                logic [TAP_W-1:0] t, logic [WORK_W-1:0] lw,
                                logic [WORK_W-1:0] rw, logic [WORK_W-1:0] ow);
    if (sel == SRC_LEFT)  return lw[addr];
    if (sel == SRC_RIGHT) return rw[addr];
    if (sel == SRC_OWN)   return ow[addr];
    if (int'(addr[2:0]) >= PIX_W) return 1'b0;
    return t[int'(sel) * PIX_W + int'(addr[2:0])];
  endfunction

  always_comb begin
    opa   = pick(ctrl.a_sel, ctrl.a_addr, taps, left_work, right_work, work_q);
    opb   = pick(ctrl.b_sel, ctrl.b_addr, taps, left_work, right_work, work_q);
    c_eff = ctrl.cin_ld ? ctrl.cin_val : carry_q;
    {cout, res} = alu_step(ctrl.op, opa, opb, c_eff);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      work_q  <= '0;
      out_q   <= '0;
      carry_q <= 1'b0;
    end else if (executes(ctrl.op)) begin
      if (ctrl.dst_we) work_q[ctrl.dst] <= res;
      if (ctrl.out_we) out_q[ctrl.out_bit] <= res;
      if (ctrl.op == OP_ADD || ctrl.op == OP_SUB) carry_q <= cout;
      else if (ctrl.cin_ld) carry_q <= ctrl.cin_val;
    end
  end

  assign work_o = work_q;
  assign out_o  = out_q;
endmodule

// File: rtl/pe_array.sv
module pe_array
  import pe_pkg::*;
#(
  parameter int NPE   = 8,
  parameter int PIX_W = 4,
  parameter int DEPTH = 128,
  parameter int SLOTS = 4,
  localparam int AW = $clog2(DEPTH),
  localparam int SW = $clog2(SLOTS),
  localparam int IW = CTRL_W + AW,
  localparam int TAP_W = NTAP * PIX_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 hsync,
  input  logic [SW-1:0]        prog_sel,
  input  logic                 im_we,
  input  logic [AW-1:0]        im_addr,
  input  logic [IW-1:0]        im_wdata,
  input  logic [NPE*TAP_W-1:0] taps,
  output logic [NPE*OUT_W-1:0] pe_out
);
  pe_ctrl_t          issue;
  logic [AW-1:0]     seq_pc, seq_tgt;
  logic              seq_jump, seq_run;
  logic              out_wr_evt;
  logic [WORK_W-1:0] work_v [NPE];

  pe_seq #(.DEPTH(DEPTH), .SLOTS(SLOTS)) u_seq (
    .clk(clk), .rst_n(rst_n), .hsync(hsync), .prog_sel(prog_sel),
    .we(im_we), .waddr(im_addr), .wdata(im_wdata),
    .issue(issue), .pc_o(seq_pc), .tgt_o(seq_tgt),
    .jump_o(seq_jump), .run_o(seq_run)
  );

  assign out_wr_evt = executes(issue.op) && issue.out_we;

  for (genvar g = 0; g < NPE; g++) begin : g_pe
    logic [WORK_W-1:0] lw, rw;
    if (g == 0) begin : g_ledge
      assign lw = '0;
    end else begin : g_lnb
      assign lw = work_v[g-1];
    end
    if (g == NPE-1) begin : g_redge
      assign rw = '0;
    end else begin : g_rnb
      assign rw = work_v[g+1];
    end
    pe_cell #(.PIX_W(PIX_W)) u_pe (
      .clk(clk), .rst_n(rst_n), .ctrl(issue),
      .taps(taps[g*TAP_W +: TAP_W]),
      .left_work(lw), .right_work(rw),
      .work_o(work_v[g]),
      .out_o(pe_out[g*OUT_W +: OUT_W])
    );
  end
endmodule

// File: rtl/pe_array_chk.sv
module pe_array_chk
  import pe_pkg::*;
#(
  parameter int NPE   = 8,
  parameter int DEPTH = 128,
  parameter int SLOTS = 4,
  localparam int AW = $clog2(DEPTH),
  localparam int SW = $clog2(SLOTS),
  localparam int SLOT_SZ = DEPTH / SLOTS
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 hsync,
  input logic [SW-1:0]        prog_sel,
  input logic [3:0]           issue_op,
  input logic [AW-1:0]        pc,
  input logic [AW-1:0]        tgt,
  input logic                 jump,
  input logic                 run,
  input logic                 out_wr_evt,
  input logic [NPE*OUT_W-1:0] pe_out
);
  // R1
  idle_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> issue_op == 4'(OP_NOP));

  // R2
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hsync |=> (pc == AW'(int'($past(prog_sel)) * SLOT_SZ)) && issue_op == 4'(OP_NOP));

  // R3
  advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !jump && !hsync) |=> pc == $past(pc) + 1'b1);

  // R4
  jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (jump && !hsync) |=> (pc == $past(tgt)) && issue_op == 4'(OP_NOP));

  // R10
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_wr_evt |=> $stable(pe_out));

  // R12
  nop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_op == 4'(OP_NOP) |=> $stable(pe_out));
endmodule

bind pe_array pe_array_chk #(.NPE(NPE), .DEPTH(DEPTH), .SLOTS(SLOTS)) u_chk (
  .clk(clk), .rst_n(rst_n), .hsync(hsync), .prog_sel(prog_sel),
  .issue_op(issue.op), .pc(seq_pc), .tgt(seq_tgt), .jump(seq_jump),
  .run(seq_run), .out_wr_evt(out_wr_evt), .pe_out(pe_out)
);

// File: tb/tb_pe_array.sv
`timescale 1ns/1ps
module tb_pe_array;
  localparam int NPE = 8, PW = 4, NT = 5, AW = 7, IW = 39, SLOT = 32;

  logic clk = 1'b0, rst_n = 1'b0, hsync = 1'b0, im_we = 1'b0;
  logic [1:0] prog_sel = '0;
  logic [AW-1:0] im_addr = '0;
  logic [IW-1:0] im_wdata = '0;
  logic [NPE*NT*PW-1:0] taps = '0;
  logic [NPE*8-1:0] pe_out;

  int total = 0, bad = 0;
  bit finished = 0;
  int pix [NPE][NT];

  always #2.5 clk = ~clk;

  pe_array dut (.clk(clk), .rst_n(rst_n), .hsync(hsync), .prog_sel(prog_sel),
    .im_we(im_we), .im_addr(im_addr), .im_wdata(im_wdata), .taps(taps), .pe_out(pe_out));

  // word layout per R12
  function automatic logic [IW-1:0] w(int op, int as, int aa, int bs, int ba,
      int dst, int dwe, int owe, int ob, int cl, int cv, int tg);
    logic [IW-1:0] v = '0;
    v[3:0] = 4'(op); v[6:4] = 3'(as); v[11:7] = 5'(aa); v[14:12] = 3'(bs);
    v[19:15] = 5'(ba); v[24:20] = 5'(dst); v[25] = 1'(dwe); v[26] = 1'(owe);
    v[29:27] = 3'(ob); v[30] = 1'(cl); v[31] = 1'(cv); v[38:32] = 7'(tg);
    return v;
  endfunction

  task automatic put(int addr, logic [IW-1:0] d);
    @(negedge clk); im_we = 1'b1; im_addr = AW'(addr); im_wdata = d;
    @(negedge clk); im_we = 1'b0;
  endtask

  task automatic check(string req, int pe, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s pe%0d actual=%0d expected=%0d", req, pe, act, exp);
    end
  endtask

  function automatic int outb(int pe);
    return int'(pe_out[pe*8 +: 8]);
  endfunction

  task automatic drive_pix(bit rnd);
    for (int p = 0; p < NPE; p++)
      for (int r = 0; r < NT; r++) begin
        if (rnd) pix[p][r] = int'($urandom % 16);
        taps[(p*NT + r)*PW +: PW] = PW'(pix[p][r]);
      end
  endtask

  task automatic pulse(int slot);
    @(negedge clk); hsync = 1'b1; prog_sel = 2'(slot);
    @(negedge clk); hsync = 1'b0;
  endtask

  task automatic run(int slot);
    pulse(slot);
    repeat (40) @(negedge clk);
  endtask

  task automatic load_programs();
    int b;
    // slot 1: 4-neighbour sum (R5, R8, R9)
    b = SLOT;
    for (int i = 0; i < 4; i++) put(b + i, w(6, 2, i, 0, 0, i, 1, 0, 0, 0, 0, 0));
    for (int i = 0; i < 5; i++) put(b + 4 + i, w(1, 1, i, 3, i, 8 + i, 1, 0, 0, i == 0, 0, 0));
    for (int i = 0; i < 6; i++) put(b + 9 + i, w(1, 7, 8 + i, 5, i, 16 + i, 1, 0, 0, i == 0, 0, 0));
    for (int i = 0; i < 6; i++) put(b + 15 + i, w(1, 7, 16 + i, 6, i, 24 + i, 1, 1, i, i == 0, 0, 0));
    put(b + 21, w(8, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, b + 21));
    // slot 2: subtract with borrow flag (R5, R7)
    b = 2 * SLOT;
    for (int i = 0; i < 4; i++) put(b + i, w(2, 0, i, 1, i, 0, 0, 1, i, i == 0, 1, 0));
    put(b + 4, w(7, 0, 0, 0, 0, 0, 0, 1, 4, 0, 0, 0));
    put(b + 5, w(8, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, b + 5));
    // slot 3: AND / OR (R6)
    b = 3 * SLOT;
    for (int i = 0; i < 4; i++) put(b + i, w(3, 0, i, 1, i, 0, 0, 1, i, 0, 0, 0));
    for (int i = 0; i < 4; i++) put(b + 4 + i, w(4, 0, i, 1, i, 0, 0, 1, 4 + i, 0, 0, 0));
    put(b + 8, w(8, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, b + 8));
    // slot 0: XOR, jump over a word, MOV (R4, R6, R12)
    put(0, w(6, 0, 7, 0, 0, 0, 0, 1, 4, 0, 0, 0));
    for (int i = 0; i < 4; i++) put(1 + i, w(5, 2, i, 3, i, 0, 0, 1, i, 0, 0, 0));
    put(5, w(8, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 7));
    put(6, w(6, 4, 0, 0, 0, 0, 0, 1, 4, 0, 0, 0));
    for (int i = 0; i < 3; i++) put(7 + i, w(6, 0, i, 0, 0, 0, 0, 1, 5 + i, 0, 0, 0));
    put(10, w(0, 4, 0, 4, 0, 3, 1, 1, 4, 1, 1, 0));  // no-op with all flags set
    put(11, w(8, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 11));
  endtask

  task automatic t_reset();
    for (int p = 0; p < NPE; p++) check("R1", p, outb(p), 0);
    repeat (10) @(negedge clk);  // no pulse yet: still idle
    for (int p = 0; p < NPE; p++) check("R1 idle", p, outb(p), 0);
  endtask

  task automatic t_sum();
    for (int row = 0; row < 4; row++) begin
      drive_pix(1);
      if (row == 3) for (int p = 0; p < NPE; p++) for (int r = 0; r < NT; r++) begin
        pix[p][r] = 15; taps[(p*NT + r)*PW +: PW] = 4'hF;
      end
      run(1);
      for (int p = 0; p < NPE; p++) begin
        int e = pix[p][1] + pix[p][3] + (p > 0 ? pix[p-1][2] : 0) + (p < NPE-1 ? pix[p+1][2] : 0);
        check((p == 0 || p == NPE-1) ? "R9 sum edge" : "R8 sum", p, outb(p) & 63, e);
      end
    end
  endtask

  task automatic t_sub();
    for (int row = 0; row < 3; row++) begin
      drive_pix(1);
      if (row == 2) begin pix[2][1] = pix[2][0]; taps[(2*NT + 1)*PW +: PW] = PW'(pix[2][0]); end
      run(2);
      for (int p = 0; p < NPE; p++) begin
        int e = ((pix[p][0] - pix[p][1]) & 15) | ((pix[p][0] >= pix[p][1]) ? 16 : 0);
        check("R5 R7 sub", p, outb(p) & 31, e);
      end
    end
  endtask

  task automatic t_logic();
    drive_pix(1);
    run(3);
    for (int p = 0; p < NPE; p++)
      check("R6 and/or", p, outb(p), (pix[p][0] & pix[p][1]) | ((pix[p][0] | pix[p][1]) << 4));
  endtask

  task automatic t_jump();
    drive_pix(1);
    for (int p = 0; p < NPE; p++) begin pix[p][4] |= 1; taps[(p*NT + 4)*PW] = 1'b1; end
    run(0);
    for (int p = 0; p < NPE; p++)
      check("R4 R12 jump", p, outb(p), (pix[p][2] ^ pix[p][3]) | ((pix[p][0] & 7) << 5));
  endtask

  task automatic t_hold();
    int keep [NPE];
    for (int p = 0; p < NPE; p++) keep[p] = outb(p);
    drive_pix(1);
    repeat (20) @(negedge clk);
    for (int p = 0; p < NPE; p++) check("R10 hold", p, outb(p), keep[p]);
  endtask

  task automatic t_restart();
    drive_pix(1);
    pulse(1);
    repeat (3) @(negedge clk);
    run(2);
    for (int p = 0; p < NPE; p++) begin
      int e = ((pix[p][0] - pix[p][1]) & 15) | ((pix[p][0] >= pix[p][1]) ? 16 : 0);
      check("R2 restart", p, outb(p) & 31, e);
    end
  endtask

  task automatic t_rewrite();
    int b = 3 * SLOT;
    for (int i = 0; i < 5; i++) put(b + i, w(1, 0, i, 1, i, 0, 0, 1, i, i == 0, 1, 0));
    put(b + 5, w(8, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, b + 5));
    drive_pix(1);
    run(3);
    for (int p = 0; p < NPE; p++)
      check("R11 R5 add+1", p, outb(p) & 31, pix[p][0] + pix[p][1] + 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    load_programs();
    t_sum();
    t_sub();
    t_logic();
    t_jump();
    t_hold();
    t_restart();
    t_rewrite();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule